// File: doc/BRIEF.md
# Serial-Number Isolation Participant

This block is the per-card half of a bit-serial isolation contest. Each card sits on one shared wired-OR line and holds a fixed-width serial number that no other card shares. During a round, every card that has not yet been given a handle presents its serial number on that line, one bit at a time, starting with the top bit. A 1 is driven actively. A 0 is left open, so the line reads 1 whenever any contender drives 1. A contender that leaves the line open but senses a 1 has met a larger number, and it withdraws until the round ends.

Each bit occupies two consecutive strobed slots, which makes a wrong decision less likely. At the end of a round, exactly one contender is still in: the card with the largest serial number. That card raises `isolated`. A handle write then gives it its handle, and it never takes part in the contest again. Cards that withdrew rejoin at the next round start. The controller repeats rounds until every card holds a handle.

Top module: `isol_arbiter`

## Requirements
- R1: After reset, `line_drive`, `isolated` and `handle_valid` are all 0, and the card stays idle until a round start.
- R2: A `round_start` pulse on a card without a handle makes it a contender. Its first strobed slot presents the most significant serial bit.
- R3: While a contender, `line_drive` equals the current serial bit. Bits run from most to least significant, and each bit holds for two consecutive `bit_strobe` slots, 2*SERIAL_W slots in all.
- R4: A contender whose current bit is 0 and that samples `line_in` = 1 at a strobed slot (either slot of the pair) withdraws. `line_drive` stays 0 and `isolated` stays 0 for the rest of the round.
- R5: A contender sending 0 while the line reads 0 stays in the round.
- R6: After the final (2*SERIAL_W-th) slot, `isolated` is 1 exactly when the card is still a contender. Strobes after the final slot change nothing, and `line_drive` is 0 then.
- R7: `handle_wr` while `isolated` is 1 loads `handle_in` into `handle_q`, sets `handle_valid` and clears `isolated`. `handle_wr` at any other time is ignored.
- R8: A card with `handle_valid` set never drives the line and never becomes isolated in later rounds. Its handle does not change.
- R9: A card that withdrew, or that never got a handle, rejoins at the next `round_start`.
- R10: When `round_start` and an accepted `handle_wr` arrive in the same cycle, the handle is taken and the card does not rejoin.
- R11: A `round_start` in the middle of a round restarts the bit sequence from the most significant bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| serial_id | input | SERIAL_W | This card's unique serial number |
| round_start | input | 1 | Begin a new isolation round |
| bit_strobe | input | 1 | One line slot; the line is sampled at this edge |
| line_in | input | 1 | Sensed value of the shared wired-OR line |
| handle_wr | input | 1 | Handle assignment strobe |
| handle_in | input | HANDLE_W | Handle value offered |
| line_drive | output | 1 | 1 = actively drive 1; 0 = leave line open |
| isolated | output | 1 | Card survived the completed round |
| handle_valid | output | 1 | Card holds a handle |
| handle_q | output | HANDLE_W | Assigned handle |

## Verification
The functions that can collide are handle acceptance and the start of a new round. A controller may write the handle and open the next round on the same edge. The bench provokes this by raising `round_start` and `handle_wr` together while `isolated` is high. It then judges the result at the ports: `handle_valid` and the offered handle must appear, and a full round of strobes must follow with `line_drive` held at 0 and `isolated` staying 0. A competing card with its own independent withdrawal model shares the line in the other rounds.

// File: rtl/isol_pkg.sv
package isol_pkg;
    parameter int HANDLE_W = 8;

    typedef struct packed {
        logic                contend;
        logic                has_handle;
        logic [HANDLE_W-1:0] handle;
    } card_state_t;
endpackage

// File: rtl/isol_step_ctr.sv
module isol_step_ctr #(
    parameter int SERIAL_W = 64,
    localparam int IW = $clog2(SERIAL_W)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          restart,
    input  logic          step,
    output logic [IW-1:0] bit_idx,
    output logic          done
);
    typedef struct packed {
        logic [IW-1:0] idx;
        logic          second;
        logic          done;
    } ctr_t;

    localparam logic [IW-1:0] TOP = IW'(SERIAL_W - 1);

    ctr_t c_d, c_q;

    always_comb begin
        c_d = c_q;
        if (restart) begin
            c_d.idx    = TOP;
            c_d.second = 1'b0;
            c_d.done   = 1'b0;
        end else if (step && !c_q.done) begin
            if (!c_q.second) begin
                c_d.second = 1'b1;
            end else begin
                c_d.second = 1'b0;
                if (c_q.idx == '0) c_d.done = 1'b1;
                else               c_d.idx  = c_q.idx - 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            c_q.idx    <= TOP;
            c_q.second <= 1'b0;
            c_q.done   <= 1'b1;
        end else begin
            c_q <= c_d;
        end
    end

    assign bit_idx = c_q.idx;
    assign done    = c_q.done;
endmodule

// File: rtl/isol_bit_pick.sv
module isol_bit_pick #(
    parameter int SERIAL_W = 64,
    localparam int IW = $clog2(SERIAL_W)
) (
    input  logic [SERIAL_W-1:0] serial,
    input  logic [IW-1:0]       bit_idx,
    input  logic                done,
    output logic                cur_bit
);
    logic [SERIAL_W-1:0] onehot;

    for (genvar g = 0; g < SERIAL_W; g++) begin : g_sel
        assign onehot[g] = (bit_idx == IW'(g)) && serial[g];
    end

    assign cur_bit = !done && (|onehot);
endmodule

// File: rtl/isol_arbiter.sv
module isol_arbiter #(
    parameter int SERIAL_W = 64,
    parameter int HANDLE_W = isol_pkg::HANDLE_W,
    localparam int IW = $clog2(SERIAL_W)
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [SERIAL_W-1:0] serial_id,
    input  logic                round_start,
    input  logic                bit_strobe,
    input  logic                line_in,
    input  logic                handle_wr,
    input  logic [HANDLE_W-1:0] handle_in,
    output logic                line_drive,
    output logic                isolated,
    output logic                handle_valid,
    output logic [HANDLE_W-1:0] handle_q
);
    import isol_pkg::*;

    card_state_t st_d, st_q;
    logic [IW-1:0] bit_idx;
    logic          done;
    logic          cur_bit;
    logic          take_handle;
    logic          lost_slot;

    isol_step_ctr #(.SERIAL_W(SERIAL_W)) u_ctr (
        .clk     (clk),
        .rst_n   (rst_n),
        .restart (round_start),
        .step    (bit_strobe),
        .bit_idx (bit_idx),
        .done    (done)
    );

    isol_bit_pick #(.SERIAL_W(SERIAL_W)) u_pick (
        .serial  (serial_id),
        .bit_idx (bit_idx),
        .done    (done),
        .cur_bit (cur_bit)
    );

    assign take_handle = handle_wr && st_q.contend && done;
    assign lost_slot   = bit_strobe && st_q.contend && !done && !cur_bit && line_in;

    always_comb begin
        st_d = st_q;
        if (take_handle) begin
            st_d.has_handle = 1'b1;
            st_d.handle     = handle_in[HANDLE_W-1:0];
            st_d.contend    = 1'b0;
        end else if (round_start) begin
            st_d.contend = !st_q.has_handle;
        end else if (lost_slot) begin
            st_d.contend = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign line_drive   = st_q.contend && cur_bit;
    assign isolated     = st_q.contend && done;
    assign handle_valid = st_q.has_handle;
    assign handle_q     = st_q.handle;
endmodule

// File: rtl/isol_arbiter_chk.sv
module isol_arbiter_chk #(
    parameter int HANDLE_W = 8
) (
    input logic                clk,
    input logic                rst_n,
    input logic                round_start,
    input logic                bit_strobe,
    input logic                line_in,
    input logic                handle_wr,
    input logic [HANDLE_W-1:0] handle_in,
    input logic                line_drive,
    input logic                isolated,
    input logic                handle_valid,
    input logic [HANDLE_W-1:0] handle_q
);
    // R4
    open_zero_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bit_strobe && !line_drive && line_in && !round_start) |=> !line_drive);

    // R6
    isolated_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        isolated |-> !line_drive);

    // R7
    handle_take_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (handle_wr && isolated) |=> (handle_valid && !isolated && handle_q == $past(handle_in)));

    // R8
    handle_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        handle_valid |=> (handle_valid && $stable(handle_q)));

    // R8
    handle_retired_chk: assert property (@(posedge clk) disable iff (!rst_n)
        handle_valid |-> (!line_drive && !isolated));
endmodule

bind isol_arbiter isol_arbiter_chk #(.HANDLE_W(HANDLE_W)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .round_start  (round_start),
    .bit_strobe   (bit_strobe),
    .line_in      (line_in),
    .handle_wr    (handle_wr),
    .handle_in    (handle_in),
    .line_drive   (line_drive),
    .isolated     (isolated),
    .handle_valid (handle_valid),
    .handle_q     (handle_q)
);

// File: tb/tb_isol_arbiter.sv
`timescale 1ns/1ps
module tb_isol_arbiter;
    localparam int SW = 64;
    localparam int HW = 8;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [SW-1:0] serial_id = '0;
    logic          round_start = 1'b0;
    logic          bit_strobe = 1'b0;
    logic          rival_drv = 1'b0;
    logic          line_in;
    logic          handle_wr = 1'b0;
    logic [HW-1:0] handle_in = '0;
    logic          line_drive, isolated, handle_valid;
    logic [HW-1:0] handle_q;

    int n_chk = 0;
    int n_bad = 0;
    logic exp_hv = 1'b0;
    logic [HW-1:0] exp_h = '0;

    always #2.5 clk = ~clk;

    assign line_in = line_drive | rival_drv;

    isol_arbiter #(.SERIAL_W(SW), .HANDLE_W(HW)) dut (
        .clk(clk), .rst_n(rst_n), .serial_id(serial_id),
        .round_start(round_start), .bit_strobe(bit_strobe), .line_in(line_in),
        .handle_wr(handle_wr), .handle_in(handle_in),
        .line_drive(line_drive), .isolated(isolated),
        .handle_valid(handle_valid), .handle_q(handle_q)
    );

    task automatic check(input logic ok, input string req, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        round_start = 0; bit_strobe = 0; handle_wr = 0; rival_drv = 0;
        exp_hv = 0; exp_h = '0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
    endtask

    // one round; rival shares the line; returns own survival per model
    task automatic run_round(input logic ren, input logic [SW-1:0] rv, input int nsteps,
                             input string req, output logic alive);
        logic rv_alive;
        int   errs;
        logic [63:0] first_act, first_exp;
        round_start = 1'b1;
        @(negedge clk);
        round_start = 1'b0;
        alive = !exp_hv;
        rv_alive = ren;
        errs = 0; first_act = 0; first_exp = 0;
        for (int k = 0; k < nsteps; k++) begin
            int b;
            logic ln;
            logic e;
            b = SW - 1 - (k / 2);
            rival_drv  = rv_alive & rv[b];
            bit_strobe = 1'b1;
            #1;
            e = alive & serial_id[b];
            if (line_drive !== e) begin
                if (errs == 0) begin first_act = {63'd0, line_drive}; first_exp = {63'd0, e}; end
                errs++;
            end
            ln = line_in;
            @(posedge clk);
            if (alive && !serial_id[b] && ln) alive = 1'b0;
            if (rv_alive && !rv[b] && ln) rv_alive = 1'b0;
            @(negedge clk);
        end
        bit_strobe = 1'b0;
        rival_drv  = 1'b0;
        #1;
        check(errs == 0, {req, " R3 drive sequence"}, first_act, first_exp);
        if (nsteps == 2 * SW)
            check(isolated === alive, {req, " R6 isolated at end"}, {63'd0, isolated}, {63'd0, alive});
        @(negedge clk);
    endtask

    task automatic write_handle(input logic [HW-1:0] h, input logic with_start);
        logic was_iso;
        was_iso = isolated;
        handle_wr = 1'b1; handle_in = h; round_start = with_start;
        @(negedge clk);
        handle_wr = 1'b0; round_start = 1'b0;
        if (was_iso && !exp_hv) begin exp_hv = 1'b1; exp_h = h; end
    endtask

    task automatic t_reset();
        do_reset();
        check(line_drive === 0 && isolated === 0 && handle_valid === 0, "R1 reset outputs",
              {61'd0, line_drive, isolated, handle_valid}, 64'd0);
        bit_strobe = 1'b1; repeat (3) @(negedge clk); bit_strobe = 1'b0;
        check(line_drive === 0 && isolated === 0, "R1 idle before round",
              {62'd0, line_drive, isolated}, 64'd0);
    endtask

    task automatic t_alone();
        logic a;
        do_reset();
        serial_id = 64'hA5C3_0F96_1E2D_7B48;
        run_round(1'b0, '0, 2 * SW, "R2", a);
        check(isolated === 1'b1, "R2 lone card isolated", {63'd0, isolated}, 64'd1);
        bit_strobe = 1'b1; rival_drv = 1'b1; repeat (3) @(negedge clk);
        bit_strobe = 1'b0; rival_drv = 1'b0; #1;
        check(isolated === 1'b1 && line_drive === 1'b0, "R6 extra strobes ignored",
              {62'd0, isolated, line_drive}, 64'd2);
        @(negedge clk);
    endtask

    task automatic t_lose_rejoin();
        logic a;
        do_reset();
        serial_id = 64'h7000_0000_0000_0001;
        run_round(1'b1, 64'h7800_0000_0000_0000, 2 * SW, "R4", a);
        check(isolated === 1'b0 && a === 1'b0, "R4 lower number withdraws",
              {63'd0, isolated}, 64'd0);
        write_handle(8'h3C, 1'b0);
        check(handle_valid === 1'b0, "R7 write ignored when not isolated",
              {63'd0, handle_valid}, 64'd0);
        run_round(1'b0, '0, 2 * SW, "R9", a);
        check(isolated === 1'b1, "R9 rejoin and win", {63'd0, isolated}, 64'd1);
    endtask

    task automatic t_zero_tie();
        logic a;
        do_reset();
        serial_id = 64'h00FF_0000_0000_0000;
        run_round(1'b1, 64'h00F0_FFFF_FFFF_FFFF, 2 * SW, "R5", a);
        check(isolated === 1'b1, "R5 shared zeros keep card in", {63'd0, isolated}, 64'd1);
    endtask

    task automatic t_handle_retire();
        logic a;
        do_reset();
        serial_id = 64'hFFFF_0000_1234_5678;
        run_round(1'b1, 64'h8000_0000_0000_0000, 2 * SW, "R7", a);
        write_handle(8'h5A, 1'b0);
        check(handle_valid === 1'b1 && handle_q === 8'h5A && isolated === 1'b0, "R7 handle taken",
              {47'd0, handle_valid, isolated, 7'd0, handle_q}, {47'd0, 1'b1, 1'b0, 7'd0, 8'h5A});
        run_round(1'b1, 64'h1000_0000_0000_0000, 2 * SW, "R8", a);
        check(isolated === 1'b0 && handle_q === 8'h5A, "R8 retired card stays out",
              {55'd0, isolated, handle_q}, {55'd0, 1'b0, 8'h5A});
        write_handle(8'h11, 1'b0);
        check(handle_q === 8'h5A, "R8 handle unchanged", {56'd0, handle_q}, 64'h5A);
    endtask

    task automatic t_restart();
        logic a;
        do_reset();
        serial_id = 64'h8123_4567_89AB_CDEF;
        run_round(1'b0, '0, 11, "R11", a);
        run_round(1'b0, '0, 2 * SW, "R11", a);
        check(isolated === 1'b1, "R11 restarted round completes", {63'd0, isolated}, 64'd1);
    endtask

    task automatic t_same_cycle();
        logic a;
        do_reset();
        serial_id = 64'h0000_0000_0000_00C7;
        run_round(1'b0, '0, 2 * SW, "R10", a);
        write_handle(8'hE1, 1'b1);
        check(handle_valid === 1'b1 && handle_q === 8'hE1, "R10 handle with round start",
              {55'd0, handle_valid, handle_q}, {55'd0, 1'b1, 8'hE1});
        bit_strobe = 1'b1;
        begin
            int drv = 0;
            for (int k = 0; k < 2 * SW; k++) begin
                #1; if (line_drive) drv++;
                @(negedge clk);
            end
            bit_strobe = 1'b0;
            check(drv == 0 && isolated === 1'b0, "R10 card did not rejoin",
                  drv, 64'd0);
        end
    endtask

    initial begin
        t_reset();
        t_alone();
        t_lose_rejoin();
        t_zero_tie();
        t_handle_retire();
        t_restart();
        t_same_cycle();
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

    initial begin
        #900000;
        n_chk++; n_bad++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end
endmodule